// File: doc/BRIEF.md
# Memory Address and Data Register Destination Controller

This block owns the memory data register and the virtual memory address register, each paired with one tag bit that marks whether the held word is a boxed object. Every cycle it decodes the functional destination code of the instruction in flight. From that code it decides which of the two registers takes the write data and which tag bits are reloaded. The tag values come from two instruction-word bits: the MD tag bit (instruction bit 55) and the VMA tag bit (instruction bit 54).

An earlier memory write may still be in flight, with its page-fault or collector-trap outcome not yet known. In that case a destination that could overwrite either register would destroy state the trap handler needs. The block therefore raises a freeze while such a destination sits on the bus. Once the outcome arrives it either lets the write complete unchanged or, if the write trapped, cancels it and flags an abort. The handler then sees the old contents. Both registers and their tags are also presented together on one status bus for capture by a status-register read.

Top module: `mdvma_dest_ctrl`

## Requirements
- R1: After reset, both registers and both tag bits are zero, and freeze and abort are low.
- R2: Destination code 1 (plain MD) loads MD from write data and the MD tag from the MD tag bit, one clock edge later. VMA and the VMA tag keep their values.
- R3: Destination code 2 (plain VMA) loads VMA from write data and the VMA tag from the VMA tag bit. MD and the MD tag keep their values.
- R4: Destination codes 3 and 4 (start-read and early start-read) load VMA from write data, load the MD tag from the MD tag bit and load the VMA tag from the VMA tag bit. MD data is unchanged.
- R5: Destination code 5 (VMA start-write) loads VMA and the VMA tag. MD and the MD tag keep their values.
- R6: Destination code 6 (MD start-write) loads MD from write data and reloads both tag bits from their instruction bits. VMA data is unchanged.
- R7: Destination codes 0 (none) and 7 (other functional destination) change neither register nor either tag bit.
- R8: While the write-pending input is high, freeze rises in the same cycle as a trigger destination is presented, and no register or tag changes while freeze is high. Codes 1 to 6 are trigger destinations. Code 7 is also one when the FREEZE_ANY parameter is 1, which is the default.
- R9: Freeze stays high through the cycle in which the write-resolved strobe arrives. It is low in the following cycle.
- R10: If the resolved write did not trap, the held destination write takes effect at the clock edge that ends the first unfrozen cycle.
- R11: If the resolved write trapped, abort is high in the cycle after the strobe, and the held destination write is inhibited in that cycle.
- R12: Freeze is never high while write-pending is low. Abort is high only in the cycle directly after a strobe that ended a freeze, and only while the held destination is still presented.
- R13: The status output always equals the concatenation, from most to least significant bit, of MD tag, VMA tag, VMA and MD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dest_code | input | 3 | Functional destination code of the current instruction |
| ir_md_tag | input | 1 | Instruction bit 55, source of the MD tag |
| ir_vma_tag | input | 1 | Instruction bit 54, source of the VMA tag |
| wr_data | input | DATA_W | Data written to the selected register |
| mem_wr_pend | input | 1 | An earlier memory write has not yet resolved its trap outcome |
| mem_wr_done | input | 1 | Strobe: the pending write's trap outcome is valid this cycle |
| mem_wr_trap | input | 1 | With the strobe: the pending write trapped |
| md_q | output | DATA_W | Memory data register |
| vma_q | output | DATA_W | Virtual memory address register |
| md_tag | output | 1 | MD tag bit |
| vma_tag | output | 1 | VMA tag bit |
| freeze | output | 1 | Hold the pipeline; the destination write is held off |
| abort | output | 1 | The held destination write was cancelled by a trapping write |
| status | output | 2*DATA_W+2 | {md_tag, vma_tag, vma_q, md_q} |

## Verification
Register and tag updates land one clock edge after the destination is presented. The bench therefore drives inputs on a falling edge and compares the outputs on the next falling edge against a model. The model applies each requirement's load rules. Freeze and abort are combinational on the current destination and on state captured at the previous edge, so they are sampled one time unit after the driving falling edge, inside the same cycle. Each frozen scenario is followed cycle by cycle: freeze is checked on entry, again in the strobe cycle, and again in the release cycle. The registers are compared only after the edge that ends the release cycle.

// File: rtl/mdvma_pkg.sv
package mdvma_pkg;

   localparam int unsigned DEST_W = 3;

   typedef enum logic [DEST_W-1:0] {
      DST_NONE     = 3'd0,
      DST_MD       = 3'd1,
      DST_VMA      = 3'd2,
      DST_RD       = 3'd3,
      DST_RD_EARLY = 3'd4,
      DST_VMA_WR   = 3'd5,
      DST_MD_WR    = 3'd6,
      DST_OTHER    = 3'd7
   } dest_e;

   // Write enables requested by one destination code.
   typedef struct packed {
      logic md_data;
      logic vma_data;
      logic md_tag;
      logic vma_tag;
   } dest_dec_t;

   localparam int unsigned LANES    = 2;
   localparam int unsigned LANE_MD  = 0;
   localparam int unsigned LANE_VMA = 1;

endpackage

// File: rtl/mdvma_dest_decode.sv
module mdvma_dest_decode
   import mdvma_pkg::*;
#(
   parameter bit FREEZE_ANY = 1'b1
) (
   input  logic [DEST_W-1:0] dest_code,
   output dest_dec_t         dec,
   output logic              trig
);

   dest_e code;
   logic  touches;

   assign code = dest_e'(dest_code);

   always_comb begin
      dec = '0;
      unique case (code)
         DST_MD: begin
            dec.md_data = 1'b1;
            dec.md_tag  = 1'b1;
         end
         DST_VMA: begin
            dec.vma_data = 1'b1;
            dec.vma_tag  = 1'b1;
         end
         DST_RD, DST_RD_EARLY: begin
            dec.vma_data = 1'b1;
            dec.md_tag   = 1'b1;
            dec.vma_tag  = 1'b1;
         end
         DST_VMA_WR: begin
            dec.vma_data = 1'b1;
            dec.vma_tag  = 1'b1;
         end
         DST_MD_WR: begin
            dec.md_data = 1'b1;
            dec.md_tag  = 1'b1;
            dec.vma_tag = 1'b1;
         end
         default: dec = '0;
      endcase
   end

   assign touches = |dec;

   generate
      if (FREEZE_ANY) begin : g_trig_any
         assign trig = (code != DST_NONE);
      end else begin : g_trig_exact
         assign trig = touches;
      end
   endgenerate

endmodule

// File: rtl/mdvma_hazard.sv
module mdvma_hazard (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   input  logic wr_pend,
   input  logic wr_done,
   input  logic wr_trap,
   output logic freeze,
   output logic abort,
   output logic commit
);

   logic res_q;
   logic trap_q;

   // res_q marks the single cycle after a strobe that ended a freeze.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q  <= 1'b0;
         trap_q <= 1'b0;
      end else begin
         res_q  <= wr_done & freeze;
         trap_q <= wr_trap & wr_done;
      end
   end

   assign freeze = trig & wr_pend & ~res_q;
   assign abort  = trig & res_q & trap_q;
   assign commit = ~freeze & ~abort;

   assert_idle_no_freeze_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_pend |-> !freeze);

   assert_abort_after_strobe_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> ($past(wr_done) && $past(freeze) && $past(wr_trap)));

   assert_release_after_strobe_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && wr_done) |=> !freeze);

   assert_not_both_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      !(freeze && abort));

endmodule

// File: rtl/mdvma_regs.sv
module mdvma_regs
   import mdvma_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dest_dec_t         dec,
   input  logic              commit,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ir_md_tag,
   input  logic              ir_vma_tag,
   output logic [DATA_W-1:0] md_q,
   output logic [DATA_W-1:0] vma_q,
   output logic              md_tag,
   output logic              vma_tag
);

   logic [LANES-1:0]  data_we;
   logic [LANES-1:0]  tag_we;
   logic [LANES-1:0]  tag_in;
   logic [DATA_W-1:0] lane_data [LANES];
   logic [LANES-1:0]  lane_tag;

   assign data_we[LANE_MD]  = commit & dec.md_data;
   assign data_we[LANE_VMA] = commit & dec.vma_data;
   assign tag_we[LANE_MD]   = commit & dec.md_tag;
   assign tag_we[LANE_VMA]  = commit & dec.vma_tag;
   assign tag_in[LANE_MD]   = ir_md_tag;
   assign tag_in[LANE_VMA]  = ir_vma_tag;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic [DATA_W-1:0] d_q;
         logic              t_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               d_q <= '0;
               t_q <= 1'b0;
            end else begin
               if (data_we[i]) d_q <= wr_data;
               if (tag_we[i])  t_q <= tag_in[i];
            end
         end
         assign lane_data[i] = d_q;
         assign lane_tag[i]  = t_q;
      end
   endgenerate

   assign md_q    = lane_data[LANE_MD];
   assign vma_q   = lane_data[LANE_VMA];
   assign md_tag  = lane_tag[LANE_MD];
   assign vma_tag = lane_tag[LANE_VMA];

   // R8 and R11: a blocked cycle leaves every register and tag as it was.
   assert_blocked_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(md_q) && $stable(vma_q) && $stable(md_tag) && $stable(vma_tag)));

endmodule

// File: rtl/mdvma_dest_ctrl.sv
module mdvma_dest_ctrl
   import mdvma_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter bit          FREEZE_ANY = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2:0]            dest_code,
   input  logic                  ir_md_tag,
   input  logic                  ir_vma_tag,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  mem_wr_pend,
   input  logic                  mem_wr_done,
   input  logic                  mem_wr_trap,
   output logic [DATA_W-1:0]     md_q,
   output logic [DATA_W-1:0]     vma_q,
   output logic                  md_tag,
   output logic                  vma_tag,
   output logic                  freeze,
   output logic                  abort,
   output logic [2*DATA_W+1:0]   status
);

   localparam int unsigned STAT_W = 2 * DATA_W + 2;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("mdvma_dest_ctrl: DATA_W must be at least 1");
      end
      if (STAT_W != $bits(status)) begin : g_bad_status
         $error("mdvma_dest_ctrl: status width mismatch");
      end
   endgenerate

   dest_dec_t dec;
   logic      trig;
   logic      commit;

   mdvma_dest_decode #(.FREEZE_ANY(FREEZE_ANY)) u_decode (
      .dest_code (dest_code),
      .dec       (dec),
      .trig      (trig)
   );

   mdvma_hazard u_hazard (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (trig),
      .wr_pend (mem_wr_pend),
      .wr_done (mem_wr_done),
      .wr_trap (mem_wr_trap),
      .freeze  (freeze),
      .abort   (abort),
      .commit  (commit)
   );

   mdvma_regs #(.DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .dec        (dec),
      .commit     (commit),
      .wr_data    (wr_data),
      .ir_md_tag  (ir_md_tag),
      .ir_vma_tag (ir_vma_tag),
      .md_q       (md_q),
      .vma_q      (vma_q),
      .md_tag     (md_tag),
      .vma_tag    (vma_tag)
   );

   assign status = {md_tag, vma_tag, vma_q, md_q};

   assert_md_start_write_tags_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (dest_code == 3'd6 && !freeze && !abort)
      |=> (md_tag == $past(ir_md_tag) && vma_tag == $past(ir_vma_tag)));

   assert_vma_start_write_keeps_md_tag_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (dest_code == 3'd5) |=> $stable(md_tag));

   assert_no_dest_keeps_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (dest_code == 3'd0 || dest_code == 3'd7) |=> ($stable(md_q) && $stable(vma_q)));

endmodule

// File: tb/mdvma_dest_ctrl_tb.sv
module mdvma_dest_ctrl_tb;

   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [2:0]    dest_code;
   logic          ir_md_tag, ir_vma_tag;
   logic [DW-1:0] wr_data;
   logic          mem_wr_pend, mem_wr_done, mem_wr_trap;
   logic [DW-1:0] md_q, vma_q;
   logic          md_tag, vma_tag, freeze, abort;
   logic [2*DW+1:0] status;

   int n_tests = 0;
   int n_fail  = 0;

   logic [DW-1:0] e_md, e_vma;
   logic          e_mt, e_vt;

   always #5 clk = ~clk;

   mdvma_dest_ctrl #(.DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .dest_code(dest_code),
      .ir_md_tag(ir_md_tag), .ir_vma_tag(ir_vma_tag), .wr_data(wr_data),
      .mem_wr_pend(mem_wr_pend), .mem_wr_done(mem_wr_done), .mem_wr_trap(mem_wr_trap),
      .md_q(md_q), .vma_q(vma_q), .md_tag(md_tag), .vma_tag(vma_tag),
      .freeze(freeze), .abort(abort), .status(status)
   );

   task automatic chk(input string req, input string what,
                      input logic [2*DW+1:0] act, input logic [2*DW+1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      chk(req, "md", md_q, e_md);
      chk(req, "vma", vma_q, e_vma);
      chk(req, "md_tag", md_tag, e_mt);
      chk(req, "vma_tag", vma_tag, e_vt);
      chk("R13", "status", status, {e_mt, e_vt, e_vma, e_md});
   endtask

   // Load rules taken from R2..R7.
   task automatic model(input logic [2:0] c, input logic [DW-1:0] d,
                        input logic tm, input logic tv);
      case (c)
         3'd1: begin e_md = d; e_mt = tm; end
         3'd2: begin e_vma = d; e_vt = tv; end
         3'd3, 3'd4: begin e_vma = d; e_mt = tm; e_vt = tv; end
         3'd5: begin e_vma = d; e_vt = tv; end
         3'd6: begin e_md = d; e_mt = tm; e_vt = tv; end
         default: ;
      endcase
   endtask

   task automatic do_dest(input logic [2:0] c, input logic [DW-1:0] d,
                          input logic tm, input logic tv, input string req);
      @(negedge clk);
      dest_code = c; wr_data = d; ir_md_tag = tm; ir_vma_tag = tv;
      #1;
      chk("R12", "freeze idle", freeze, 1'b0);
      chk("R12", "abort idle", abort, 1'b0);
      @(negedge clk);
      dest_code = 3'd0;
      model(c, d, tm, tv);
      check_all(req);
   endtask

   task automatic frozen_dest(input logic [2:0] c, input logic [DW-1:0] d,
                              input logic tm, input logic tv, input logic trap);
      @(negedge clk);
      mem_wr_pend = 1'b1;
      dest_code = c; wr_data = d; ir_md_tag = tm; ir_vma_tag = tv;
      #1 chk("R8", "freeze on entry", freeze, 1'b1);
      @(negedge clk);
      chk("R8", "freeze held", freeze, 1'b1);
      check_all("R8");
      mem_wr_done = 1'b1; mem_wr_trap = trap;
      #1 chk("R9", "freeze in strobe cycle", freeze, 1'b1);
      @(negedge clk);
      mem_wr_done = 1'b0; mem_wr_pend = 1'b0; mem_wr_trap = 1'b0;
      #1;
      chk("R9", "freeze released", freeze, 1'b0);
      chk("R11", "abort", abort, trap);
      @(negedge clk);
      dest_code = 3'd0;
      if (!trap) model(c, d, tm, tv);
      check_all(trap ? "R11" : "R10");
      #1 chk("R12", "abort after release", abort, 1'b0);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      dest_code = 3'd0; wr_data = '0; ir_md_tag = 1'b0; ir_vma_tag = 1'b0;
      mem_wr_pend = 1'b0; mem_wr_done = 1'b0; mem_wr_trap = 1'b0;
      e_md = '0; e_vma = '0; e_mt = 1'b0; e_vt = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_all("R1");
      chk("R1", "freeze", freeze, 1'b0);
      chk("R1", "abort", abort, 1'b0);
   endtask

   task automatic t_plain;
      do_dest(3'd1, 32'hA5A5_0001, 1'b1, 1'b1, "R2");
      do_dest(3'd2, 32'h0000_BEEF, 1'b0, 1'b1, "R3");
      do_dest(3'd1, 32'h1234_5678, 1'b0, 1'b0, "R2");
   endtask

   task automatic t_start_ops;
      do_dest(3'd3, 32'h0BAD_F00D, 1'b1, 1'b0, "R4");
      do_dest(3'd4, 32'hCAFE_0004, 1'b0, 1'b1, "R4");
      do_dest(3'd6, 32'h6666_0006, 1'b1, 1'b0, "R6");
      do_dest(3'd5, 32'h5555_0005, 1'b0, 1'b1, "R5");
      do_dest(3'd6, 32'h7777_0007, 1'b0, 1'b0, "R6");
   endtask

   task automatic t_ignored;
      do_dest(3'd0, 32'hFFFF_FFFF, 1'b1, 1'b1, "R7");
      do_dest(3'd7, 32'hDEAD_DEAD, 1'b1, 1'b1, "R7");
   endtask

   task automatic t_pend_idle;
      @(negedge clk);
      mem_wr_pend = 1'b1; dest_code = 3'd0;
      #1 chk("R12", "no trigger no freeze", freeze, 1'b0);
      @(negedge clk);
      mem_wr_pend = 1'b0;
      check_all("R12");
   endtask

   task automatic t_frozen;
      frozen_dest(3'd1, 32'h1111_2222, 1'b1, 1'b0, 1'b0);
      frozen_dest(3'd5, 32'h3333_4444, 1'b0, 1'b0, 1'b1);
      frozen_dest(3'd3, 32'h5555_6666, 1'b0, 1'b1, 1'b0);
      frozen_dest(3'd7, 32'h7777_8888, 1'b1, 1'b1, 1'b0);
      frozen_dest(3'd6, 32'h9999_AAAA, 1'b0, 1'b1, 1'b1);
   endtask

   initial begin : watchdog
      #2_000_000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_plain();
      t_start_ops();
      t_ignored();
      t_pend_idle();
      t_frozen();
      do_dest(3'd2, 32'h0F0F_0F0F, 1'b1, 1'b0, "R3");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule